// File: doc/BRIEF.md
# External Interrupt Flag Controller

This block captures interrupt events from a set of external pins, one channel per pin. Each pin is first brought into the clock domain through a two-flop synchroniser. Each channel is then checked against its own settings: level or edge detection, active-high/rising or active-low/falling polarity, and a function-select input that says whether the pin is assigned to the interrupt function. A qualifying event sets the channel's flag. The flag drives that channel's interrupt request output directly.

Software reaches the block through a small register bus with a write strobe and a combinational read port. Three registers are decoded: the flag register at address 0, the detection mode register at address 1 and the polarity register at address 2. Flags are cleared by writing ones to them. In level mode the clear has no lasting effect while the pin is still active, because the active level sets the flag again in the same cycle. After a change of mode, software must clear any flag that is left over.

Top module: `ext_irq_flags`

## Requirements
- R1: After reset the flag, mode and polarity registers read zero and every interrupt output is low.
- R2: In level mode (mode bit 0), a channel whose function select is high sets its flag while its synchronised pin is at the active level. Polarity bit 1 means active-high and 0 means active-low. The flag is visible at the third rising clock edge after the pin changes.
- R3: In edge mode (mode bit 1), a channel sets its flag only on the selected transition of its synchronised pin: rising when the polarity bit is 1, falling when it is 0. The opposite transition and a steady level set nothing.
- R4: A write to address 0 clears every flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged.
- R5: In level mode, a clear of a flag has no effect while that channel's pin remains active. The flag can be cleared once the pin has gone inactive.
- R6: A channel whose function select input is low never sets its flag.
- R7: When a set event and a clear of the same flag occur in the same cycle, the flag ends up set.
- R8: A flag that is set before its channel is switched from level to edge mode stays set, with no further events, until software clears it.
- R9: Register bits 7:4 read zero and ignore writes. Address 3 reads zero.
- R10: Each channel's interrupt output always equals its flag bit, as read at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 4 | Raw external pin levels, one per channel |
| func_sel | input | 4 | High when the pin is assigned to the interrupt function |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 flag, 1 mode, 2 polarity |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| irq_out | output | 4 | Per-channel interrupt request |

## Verification
A pin change reaches the flag three rising edges after it is applied: two edges for the synchroniser and one for the flag register. The bench therefore waits at least three cycles before it checks a directed pin stimulus. A register write takes effect at the next rising edge. Read data is combinational, so the bench changes inputs on the falling edge and compares shortly afterwards. A cycle model inside the bench advances on every rising edge with the same inputs, and it is compared with the outputs on every falling edge, so each result is sampled in the cycle it is due.

// File: rtl/eint_pkg.sv
package eint_pkg;

   localparam int unsigned EINT_ADDR_W = 2;

   typedef enum logic [EINT_ADDR_W-1:0] {
      REG_FLAG = 2'd0,
      REG_MODE = 2'd1,
      REG_POL  = 2'd2,
      REG_NONE = 2'd3
   } eint_reg_e;

endpackage

// File: rtl/eint_sync.sv
module eint_sync #(
   parameter int unsigned WIDTH  = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);

   if (STAGES < 2) begin : g_bad_stages
      $error("eint_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] pipe_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q[s] <= '0;
            else        pipe_q[s] <= d_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q[s] <= '0;
            else        pipe_q[s] <= pipe_q[s-1];
         end
      end
   end

   assign d_out = pipe_q[STAGES-1];

endmodule

// File: rtl/eint_detect.sv
module eint_detect #(
   parameter int unsigned NUM_CH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] pin_s,
   input  logic [NUM_CH-1:0] func_sel,
   input  logic [NUM_CH-1:0] edge_mode,
   input  logic [NUM_CH-1:0] act_high,
   output logic [NUM_CH-1:0] set_evt
);

   logic [NUM_CH-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= pin_s;
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic active;
      logic toggled;
      assign active  = act_high[c] ? pin_s[c] : ~pin_s[c];
      assign toggled = pin_s[c] ^ prev_q[c];
      always_comb begin
         if (!func_sel[c])     set_evt[c] = 1'b0;
         else if (edge_mode[c]) set_evt[c] = toggled & active;
         else                  set_evt[c] = active;
      end
   end

endmodule

// File: rtl/eint_regs.sv
module eint_regs
   import eint_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned DATA_W = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bus_wr,
   input  logic [EINT_ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0]      bus_wdata,
   input  logic [NUM_CH-1:0]      set_evt,
   output logic [NUM_CH-1:0]      flag_q,
   output logic [NUM_CH-1:0]      mode_q,
   output logic [NUM_CH-1:0]      pol_q,
   output logic [DATA_W-1:0]      bus_rdata
);

   localparam int unsigned PAD_W = DATA_W - NUM_CH;

   logic              wr_flag, wr_mode, wr_pol;
   logic [NUM_CH-1:0] wr_bits;
   logic [NUM_CH-1:0] clr_mask;

   assign wr_bits  = bus_wdata[NUM_CH-1:0];
   assign wr_flag  = bus_wr && (bus_addr == REG_FLAG);
   assign wr_mode  = bus_wr && (bus_addr == REG_MODE);
   assign wr_pol   = bus_wr && (bus_addr == REG_POL);
   assign clr_mask = wr_flag ? wr_bits : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= '0;
         mode_q <= '0;
         pol_q  <= '0;
      end else begin
         flag_q <= set_evt | (flag_q & ~clr_mask);
         if (wr_mode) mode_q <= wr_bits;
         if (wr_pol)  pol_q  <= wr_bits;
      end
   end

   always_comb begin
      unique case (bus_addr)
         REG_FLAG: bus_rdata = {{PAD_W{1'b0}}, flag_q};
         REG_MODE: bus_rdata = {{PAD_W{1'b0}}, mode_q};
         REG_POL:  bus_rdata = {{PAD_W{1'b0}}, pol_q};
         default:  bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/ext_irq_flags.sv
module ext_irq_flags
   import eint_pkg::*;
#(
   parameter int unsigned NUM_CH      = 4,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_CH-1:0]      pin_in,
   input  logic [NUM_CH-1:0]      func_sel,
   input  logic                   bus_wr,
   input  logic [EINT_ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0]      bus_wdata,
   output logic [DATA_W-1:0]      bus_rdata,
   output logic [NUM_CH-1:0]      irq_out
);

   if (NUM_CH == 0 || NUM_CH >= DATA_W) begin : g_bad_width
      $error("ext_irq_flags: NUM_CH must be between 1 and DATA_W-1");
   end

   logic [NUM_CH-1:0] pin_s;
   logic [NUM_CH-1:0] set_evt;
   logic [NUM_CH-1:0] flag_q, mode_q, pol_q;

   eint_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (pin_in),
      .d_out (pin_s)
   );

   eint_detect #(.NUM_CH(NUM_CH)) i_detect (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_s     (pin_s),
      .func_sel  (func_sel),
      .edge_mode (mode_q),
      .act_high  (pol_q),
      .set_evt   (set_evt)
   );

   eint_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .set_evt   (set_evt),
      .flag_q    (flag_q),
      .mode_q    (mode_q),
      .pol_q     (pol_q),
      .bus_rdata (bus_rdata)
   );

   assign irq_out = flag_q;

endmodule

// File: rtl/eint_checker.sv
module eint_checker
   import eint_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned DATA_W = 8
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   bus_wr,
   input logic [EINT_ADDR_W-1:0] bus_addr,
   input logic [NUM_CH-1:0]      wr_bits,
   input logic [DATA_W-1:0]      bus_rdata,
   input logic [NUM_CH-1:0]      func_sel,
   input logic [NUM_CH-1:0]      set_evt,
   input logic [NUM_CH-1:0]      irq_out
);

   // R4: a cleared flag is low next cycle unless a set event hit it
   a_r4_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == REG_FLAG) |=>
         ((irq_out & $past(wr_bits & ~set_evt)) == '0));

   // R7: a set event always leaves the flag high
   a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_evt) |=> ((irq_out & $past(set_evt)) == $past(set_evt)));

   // R6: no set event on a channel not assigned to the function
   a_r6_no_func_no_set: assert property (@(posedge clk) disable iff (!rst_n)
      (set_evt & ~func_sel) == '0);

   // R2: a flag rises only after a set event
   a_r2_rise_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out & ~$past(irq_out) & ~$past(set_evt)) == '0);

   // R9: reserved read bits stay zero
   a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[DATA_W-1:NUM_CH] == '0);

   // R10: flag register read returns the request outputs
   a_r10_irq_matches_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == REG_FLAG) |-> (bus_rdata[NUM_CH-1:0] == irq_out));

endmodule

bind ext_irq_flags eint_checker #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) i_eint_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .wr_bits   (bus_wdata[NUM_CH-1:0]),
   .bus_rdata (bus_rdata),
   .func_sel  (func_sel),
   .set_evt   (set_evt),
   .irq_out   (irq_out)
);

// File: tb/test_ext_irq_flags.sv
`timescale 1ns/1ps
module test_ext_irq_flags;

   localparam int NCH = 4;
   localparam int DW  = 8;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NCH-1:0] pin = '0;
   logic [NCH-1:0] fsel = '0;
   logic           wr = 1'b0;
   logic [1:0]     addr = 2'd0;
   logic [DW-1:0]  wdata = '0;
   logic [DW-1:0]  rdata;
   logic [NCH-1:0] irq;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   ext_irq_flags i_ext_irq_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_in    (pin),
      .func_sel  (fsel),
      .bus_wr    (wr),
      .bus_addr  (addr),
      .bus_wdata (wdata),
      .bus_rdata (rdata),
      .irq_out   (irq)
   );

   // cycle model built from the requirements
   logic [NCH-1:0] m_s1 = '0, m_s2 = '0, m_prev = '0;
   logic [NCH-1:0] m_flag = '0, m_mode = '0, m_pol = '0;

   always @(posedge clk) begin
      logic [NCH-1:0] clr, nflag;
      if (!rst_n) begin
         m_s1 = '0; m_s2 = '0; m_prev = '0;
         m_flag = '0; m_mode = '0; m_pol = '0;
      end else begin
         clr = (wr && addr == 2'd0) ? wdata[NCH-1:0] : '0;
         for (int c = 0; c < NCH; c++) begin
            bit act, hit;
            act = m_pol[c] ? m_s2[c] : !m_s2[c];
            hit = m_mode[c] ? (act && (m_s2[c] != m_prev[c])) : act;
            nflag[c] = (fsel[c] && hit) || (m_flag[c] && !clr[c]);
         end
         m_flag = nflag;
         if (wr && addr == 2'd1) m_mode = wdata[NCH-1:0];
         if (wr && addr == 2'd2) m_pol  = wdata[NCH-1:0];
         m_prev = m_s2; m_s2 = m_s1; m_s1 = pin;
      end
   end

   function automatic logic [DW-1:0] model_read(input logic [1:0] a);
      case (a)
         2'd0:    return {{(DW-NCH){1'b0}}, m_flag};
         2'd1:    return {{(DW-NCH){1'b0}}, m_mode};
         2'd2:    return {{(DW-NCH){1'b0}}, m_pol};
         default: return '0;
      endcase
   endfunction

   task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // R10 and model tracking: outputs compared on every falling edge
   always @(negedge clk) begin
      if (rst_n && !done) chk({{(DW-NCH){1'b0}}, irq}, {{(DW-NCH){1'b0}}, m_flag}, "R10 irq vs model");
   end

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr_reg(input logic [1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr = 1'b0; wdata = '0;
   endtask

   task automatic rd_chk(input logic [1:0] a, input logic [DW-1:0] exp, input string tag);
      @(negedge clk);
      wr = 1'b0; addr = a;
      #1;
      chk(rdata, exp, tag);
   endtask

   initial begin
      void'($urandom(32'd1234));
      cyc(3);
      rst_n = 1'b1;
      // R1 reset state
      rd_chk(2'd0, 8'h00, "R1 flag reset");
      rd_chk(2'd1, 8'h00, "R1 mode reset");
      rd_chk(2'd2, 8'h00, "R1 pol reset");
      chk({4'h0, irq}, 8'h00, "R1 irq reset");
      // R9 reserved bits
      wr_reg(2'd1, 8'hFF);
      rd_chk(2'd1, 8'h0F, "R9 mode reserved");
      wr_reg(2'd2, 8'hF0);
      rd_chk(2'd2, 8'h00, "R9 pol reserved");
      wr_reg(2'd3, 8'hFF);
      rd_chk(2'd3, 8'h00, "R9 addr3 zero");
      wr_reg(2'd1, 8'h00);
      // R6: pins active-low and low, no function select
      cyc(5);
      chk({4'h0, irq}, 8'h00, "R6 no function no flag");
      // R2 level active-high on channel 0
      wr_reg(2'd2, 8'h0F);
      fsel = 4'h1;
      @(negedge clk); pin[0] = 1'b1;
      cyc(2);
      chk({7'h0, irq[0]}, 8'h00, "R2 not yet after two edges");
      cyc(1);
      chk({7'h0, irq[0]}, 8'h01, "R2 level set after three edges");
      // R5 / R7 clear ignored while active
      wr_reg(2'd0, 8'h01);
      chk({7'h0, irq[0]}, 8'h01, "R5 clear ignored while active");
      chk({7'h0, irq[0]}, 8'h01, "R7 set wins over clear");
      @(negedge clk); pin[0] = 1'b0;
      cyc(4);
      chk({7'h0, irq[0]}, 8'h01, "R5 flag held after pin inactive");
      wr_reg(2'd0, 8'h00);
      chk({7'h0, irq[0]}, 8'h01, "R4 zero write keeps flag");
      wr_reg(2'd0, 8'h01);
      chk({7'h0, irq[0]}, 8'h00, "R4 one write clears flag");
      // R8 stale flag after switching to edge mode
      @(negedge clk); pin[0] = 1'b1;
      cyc(4);
      wr_reg(2'd1, 8'h01);
      cyc(6);
      chk({7'h0, irq[0]}, 8'h01, "R8 stale flag remains");
      wr_reg(2'd0, 8'h01);
      cyc(3);
      chk({7'h0, irq[0]}, 8'h00, "R8 stale flag cleared, steady level");
      // R3 edge mode: falling ignored, rising sets
      @(negedge clk); pin[0] = 1'b0;
      cyc(4);
      chk({7'h0, irq[0]}, 8'h00, "R3 opposite edge ignored");
      @(negedge clk); pin[0] = 1'b1;
      cyc(3);
      chk({7'h0, irq[0]}, 8'h01, "R3 rising edge sets");
      wr_reg(2'd0, 8'h01);
      cyc(4);
      chk({7'h0, irq[0]}, 8'h00, "R3 no re-set on steady high");
      // R3 falling edge with polarity 0
      wr_reg(2'd2, 8'h00);
      @(negedge clk); pin[0] = 1'b0;
      cyc(4);
      chk({7'h0, irq[0]}, 8'h01, "R3 falling edge sets with pol 0");
      // random phase, compared with the model each cycle
      for (int k = 0; k < 4000; k++) begin
         @(negedge clk);
         wr = 1'b0;
         for (int c = 0; c < NCH; c++)
            if ($urandom % 6 == 0) pin[c] = ~pin[c];
         if ($urandom % 40 == 0) fsel = 4'($urandom);
         if ($urandom % 8 == 0) begin
            wr = 1'b1; addr = 2'($urandom); wdata = 8'($urandom);
         end else begin
            addr = 2'($urandom);
         end
         #1;
         chk(rdata, model_read(addr), "R4 random register read");
      end
      @(negedge clk); wr = 1'b0;
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #150000;
      if (!done) begin
         done = 1'b1;
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule